// File: doc/BRIEF.md
# Reset Cause and Retention Configuration Unit

This unit records why the chip was last reset and holds one configuration byte. That byte decides whether GPIO and analog-output states are held across a watchdog or software reset. Software reads the cause bits to find out how the chip came out of reset. It acknowledges a cause by writing a mask to a write-only clear location.

The configuration byte is guarded by a three-write unlock sequence. The first write puts the unlock key 0x76 at the first key location. The second write puts the new value at the configuration location. The third write puts the commit key 0xB1 at the second key location. The byte changes only when all three writes arrive in that order with no other write between them.

The unit is reset asynchronously by power-on reset (`rst_ni` low). Watchdog, software and external resets are reported to it as one-cycle pulses. These pulses do not clear the configuration byte.

Top module: `rcu_top`

## Requirements
- R1: After power-on reset (`rst_ni` low), the status register reads 0x01 (bit 0 = power-on cause). The configuration register reads 0x00, and both retention outputs are low.
- R2: Status bits are sticky. Reads do not change them. A write to address 1 clears each status bit whose data bit is 1. A cause pulse in the same cycle as the clear write keeps its bit set.
- R3: A pulse on `wdt_rst_i` sets status bit 1, `sw_rst_i` sets bit 2 and `ext_rst_i` sets bit 3. Status bits 7:4 always read 0.
- R4: The configuration register (read and write at address 3) takes a new value only after these three consecutive bus writes: 0x76 to address 2, the value to address 3, then 0xB1 to address 4. Address 3 reads back the committed value.
- R5: Any write that is not the expected next step ends the sequence and discards the staged value. This covers a wrong key value, a write to any other address, and a second configuration write. A configuration write or a commit-key write that is not preceded by the proper earlier steps changes nothing.
- R6: The configuration register keeps its value through watchdog, software and external reset pulses. Any such pulse ends an open unlock sequence.
- R7: `keep_gpio_o` equals configuration bit 0 and `keep_dac_o` equals configuration bit 1.
- R8: Reads of addresses 1, 2 and 4, and of the unused addresses 5 to 7, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| wdt_rst_i | input | 1 | Watchdog reset occurred (one-cycle pulse) |
| sw_rst_i | input | 1 | Software reset occurred (one-cycle pulse) |
| ext_rst_i | input | 1 | External reset occurred (one-cycle pulse) |
| keep_gpio_o | output | 1 | Hold GPIO outputs across watchdog or software reset |
| keep_dac_o | output | 1 | Hold analog outputs across watchdog or software reset |

## Verification
The assertions check four things on every cycle:
- A configuration change is always preceded by a commit-key write.
- The staged state is only entered from the armed state through a configuration write.
- A reset-cause pulse always returns the sequencer to idle.
- Status bits fall only after a clear write, and rise after their cause pulse.

Only the bench scenarios can show the rest:
- The committed value for all 256 data patterns.
- That every wrong key value in each position is rejected.
- That interrupted sequences leave the register unchanged.
- That every combination of causes and clear masks gives the arithmetically expected status.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  localparam int AW      = 3;
  localparam int DW      = 8;
  localparam int N_CAUSE = 4;

  localparam logic [AW-1:0] A_STAT  = 3'd0;
  localparam logic [AW-1:0] A_CLR   = 3'd1;
  localparam logic [AW-1:0] A_KEY_A = 3'd2;
  localparam logic [AW-1:0] A_CFG   = 3'd3;
  localparam logic [AW-1:0] A_KEY_B = 3'd4;

  localparam logic [DW-1:0] KEY_A_VAL = 8'h76;
  localparam logic [DW-1:0] KEY_B_VAL = 8'hB1;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_STAGED = 2'd2
  } seq_e;
endpackage

// File: rtl/rcu_status.sv
module rcu_status
  import rcu_pkg::*;
#(
  parameter int N  = N_CAUSE,
  parameter int W  = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:1] cause_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [W-1:0] stat_o
);
  localparam int PAD = W - N;

  logic [N-1:0] stat_q;
  logic [N-1:0] clr_vec;
  logic [N-1:0] set_vec;

  assign clr_vec = clr_we_i ? clr_mask_i : '0;
  assign set_vec = {cause_i, 1'b0};

  // set wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= N'(1);
    else         stat_q <= (stat_q & ~clr_vec) | set_vec;
  end

  assign stat_o = {{PAD{1'b0}}, stat_q};

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(stat_q) & ~stat_q)) |-> $past(clr_we_i)); // R2

  AST_CAUSE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cause_i) |=> ((stat_q[N-1:1] & $past(cause_i)) == $past(cause_i))); // R3
endmodule

// File: rtl/rcu_key_seq.sv
module rcu_key_seq
  import rcu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          abort_i,
  output logic [DW-1:0] cfg_o
);
  seq_e          state_q, state_d;
  logic [DW-1:0] staged_q, staged_d;
  logic [DW-1:0] cfg_q, cfg_d;

  always_comb begin
    state_d  = state_q;
    staged_d = staged_q;
    cfg_d    = cfg_q;
    if (abort_i) begin
      state_d = SEQ_IDLE;
    end else if (wr_en_i) begin
      state_d = SEQ_IDLE;
      unique case (state_q)
        SEQ_IDLE:
          if (addr_i == A_KEY_A && wdata_i == KEY_A_VAL) state_d = SEQ_ARMED;
        SEQ_ARMED:
          if (addr_i == A_CFG) begin
            state_d  = SEQ_STAGED;
            staged_d = wdata_i;
          end
        SEQ_STAGED:
          if (addr_i == A_KEY_B && wdata_i == KEY_B_VAL) cfg_d = staged_q;
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      staged_q <= '0;
      cfg_q    <= '0;
    end else begin
      state_q  <= state_d;
      staged_q <= staged_d;
      cfg_q    <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  AST_CFG_NEEDS_KEY_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> $past(wr_en_i && addr_i == A_KEY_B && wdata_i == KEY_B_VAL)); // R4

  AST_STAGE_AFTER_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_STAGED && $past(state_q) != SEQ_STAGED)
      |-> ($past(state_q) == SEQ_ARMED && $past(wr_en_i && addr_i == A_CFG))); // R5

  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> state_q == SEQ_IDLE); // R6
endmodule

// File: rtl/rcu_top.sv
module rcu_top
  import rcu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          wdt_rst_i,
  input  logic          sw_rst_i,
  input  logic          ext_rst_i,
  output logic          keep_gpio_o,
  output logic          keep_dac_o
);
  logic [DW-1:0]        stat;
  logic [DW-1:0]        cfg;
  logic [N_CAUSE-1:1]   cause;

  assign cause = {ext_rst_i, sw_rst_i, wdt_rst_i};

  rcu_status #(.N(N_CAUSE), .W(DW)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cause_i    (cause),
    .clr_we_i   (wr_en_i && addr_i == A_CLR),
    .clr_mask_i (wdata_i[N_CAUSE-1:0]),
    .stat_o     (stat)
  );

  rcu_key_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .abort_i (|cause),
    .cfg_o   (cfg)
  );

  always_comb begin
    unique case (addr_i)
      A_STAT:  rdata_o = stat;
      A_CFG:   rdata_o = cfg;
      default: rdata_o = '0;
    endcase
  end

  assign keep_gpio_o = cfg[0];
  assign keep_dac_o  = cfg[1];
endmodule

// File: tb/rcu_top_tb.sv
module rcu_top_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       wdt_rst_i = 1'b0, sw_rst_i = 1'b0, ext_rst_i = 1'b0;
  logic       keep_gpio_o, keep_dac_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  rcu_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .wdt_rst_i(wdt_rst_i),
    .sw_rst_i(sw_rst_i), .ext_rst_i(ext_rst_i),
    .keep_gpio_o(keep_gpio_o), .keep_dac_o(keep_dac_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse(input logic [2:0] c);
    @(negedge clk_i);
    {ext_rst_i, sw_rst_i, wdt_rst_i} = c;
    @(negedge clk_i);
    {ext_rst_i, sw_rst_i, wdt_rst_i} = '0;
  endtask

  task automatic commit(input logic [7:0] v);
    wr(3'd2, 8'h76); wr(3'd3, v); wr(3'd4, 8'hB1);
  endtask

  logic [7:0] r;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(3'd0, r); chk("R1 status", r, 8'h01);
    rd(3'd3, r); chk("R1 cfg", r, 8'h00);
    chk("R1 outputs", {6'd0, keep_dac_o, keep_gpio_o}, 8'h00);

    // R8 write-only and unused addresses read zero
    for (int a = 1; a < 8; a++) begin
      if (a == 3) continue;
      rd(3'(a), r); chk("R8 zero read", r, 8'h00);
    end

    // R4 / R7 every value through full sequence
    for (int v = 0; v < 256; v++) begin
      commit(8'(v));
      rd(3'd3, r); chk("R4 commit", r, 8'(v));
      chk("R7 keep outputs", {6'd0, keep_dac_o, keep_gpio_o}, 8'(v & 3));
    end

    // R5 wrong first key
    commit(8'h5A);
    for (int k = 0; k < 256; k++) begin
      if (k == 8'h76) continue;
      wr(3'd2, 8'(k)); wr(3'd3, 8'(k) ^ 8'hFF); wr(3'd4, 8'hB1);
      rd(3'd3, r); chk("R5 bad key A", r, 8'h5A);
    end
    // R5 wrong second key, then stray commit key
    for (int k = 0; k < 256; k++) begin
      if (k == 8'hB1) continue;
      wr(3'd2, 8'h76); wr(3'd3, 8'h11); wr(3'd4, 8'(k)); wr(3'd4, 8'hB1);
      rd(3'd3, r); chk("R5 bad key B", r, 8'h5A);
    end
    // R5 interruptions
    wr(3'd2, 8'h76); wr(3'd5, 8'h00); wr(3'd3, 8'h22); wr(3'd4, 8'hB1);
    rd(3'd3, r); chk("R5 stray write after key A", r, 8'h5A);
    wr(3'd2, 8'h76); wr(3'd3, 8'h33); wr(3'd3, 8'h44); wr(3'd4, 8'hB1);
    rd(3'd3, r); chk("R5 double cfg write", r, 8'h5A);
    wr(3'd3, 8'h66); wr(3'd4, 8'hB1);
    rd(3'd3, r); chk("R5 cfg write without key", r, 8'h5A);
    wr(3'd2, 8'h76); wr(3'd3, 8'h55); wr(3'd1, 8'h00); wr(3'd4, 8'hB1);
    rd(3'd3, r); chk("R5 clear write in sequence", r, 8'h5A);

    // R6 retention across cause pulses, and abort
    pulse(3'b001); pulse(3'b010); pulse(3'b100);
    rd(3'd3, r); chk("R6 cfg retained", r, 8'h5A);
    chk("R6 outputs retained", {6'd0, keep_dac_o, keep_gpio_o}, 8'h02);
    wr(3'd2, 8'h76); pulse(3'b001); wr(3'd3, 8'h77); wr(3'd4, 8'hB1);
    rd(3'd3, r); chk("R6 pulse aborts", r, 8'h5A);
    wr(3'd2, 8'h76); wr(3'd3, 8'h78); pulse(3'b010); wr(3'd4, 8'hB1);
    rd(3'd3, r); chk("R6 pulse aborts staged", r, 8'h5A);

    // R2 / R3 all cause combinations against all clear masks
    for (int c = 0; c < 8; c++) begin
      for (int m = 0; m < 16; m++) begin
        wr(3'd1, 8'hFF);
        rd(3'd0, r); chk("R2 clear all", r, 8'h00);
        pulse(3'(c));
        rd(3'd0, r); chk("R3 cause set", r, 8'(c << 1));
        rd(3'd0, r); chk("R2 read no side effect", r, 8'(c << 1));
        wr(3'd1, 8'(m) | 8'hF0);
        rd(3'd0, r); chk("R2 masked clear", r, 8'((c << 1) & ~m & 15));
      end
    end

    // R2 set wins over same-cycle clear
    wr(3'd1, 8'hFF);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 3'd1; wdata_i = 8'hFF; wdt_rst_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdt_rst_i = 1'b0;
    rd(3'd0, r); chk("R2 set beats clear", r, 8'h02);

    // R1 power-on reset again
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rd(3'd0, r); chk("R1 status after POR", r, 8'h01);
    rd(3'd3, r); chk("R1 cfg after POR", r, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule